// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execute stage for the data-processing instructions of a compact 16-bit-encoded RISC instruction set. Each cycle it takes two operands, a 4-bit operation code and the incoming condition flags (negative N, zero Z, carry C, overflow V). One clock later it presents the result, a destination write-enable and the updated flag set. The operand datapath is `DATA_W` bits wide, and the default is 32.

The arithmetic operations share a single carry-propagating adder. Subtraction runs through the same adder as the first operand plus the inverted second operand plus one. That makes the carry out the inverse of a borrow. Subtract-with-carry takes off an extra one when the incoming carry is clear. The logic operations, move and move-not change only N and Z, and C and V pass through unchanged. Compare, compare-negative and bit test update the flags without writing the destination. The instruction decoder extracts the operands before this block sees them. An 8-bit immediate comes from opcode bits 7:0, zero-extended, with its destination in bits 10:8. A 3-bit immediate or second register comes from bits 8:6, with the first operand in bits 5:3 and the destination in bits 2:0.

Top module: `cfa_alu`

## Requirements
- R1: Operation code 0 (add) gives result = A + B modulo 2^DATA_W, sets C to the carry out of the top bit, and sets V when the signed sum is outside the signed range. Operation code 6 (compare-negative) sets the same flags.
- R2: Operation code 1 (subtract) gives A − B. Operation code 5 (compare) sets the same flags. C = 1 when A ≥ B unsigned (no borrow), and V = 1 on signed overflow of A − B.
- R3: Operation code 2 (add-with-carry) gives A + B + C_in. C and V come from the full sum including the carry-in.
- R4: Operation code 3 (subtract-with-carry) gives A − B − (1 − C_in). C = 1 when A ≥ B + (1 − C_in) unsigned, and V flags signed overflow of the whole expression.
- R5: Operation code 4 (negate) gives 0 − B with subtraction flags, so C = 1 only when B is zero and V = 1 only when B is the most negative value.
- R6: Compare (5), compare-negative (6) and bit test (7, A AND B) leave wr_en low. They still update the flags, and result shows the computed value.
- R7: AND (8), XOR (9), OR (10), bit-clear (11, A AND NOT B), move (12, result = B) and move-not (13, result = NOT B) set N and Z from the result and pass C and V from flags_in unchanged. All except test (7) assert wr_en.
- R8: For every operation code from 0 to 13, N equals the top bit of result and Z is 1 exactly when result is zero.
- R9: Outputs are registered with one cycle of latency, and out_valid follows in_valid. In a cycle after in_valid was low, wr_en is 0 and result and flags_out hold their previous values.
- R10: Operation codes 14 and 15 are undefined. They give result 0 and wr_en 0, and flags_out equals flags_in.
- R11: After reset, out_valid, wr_en, result and flags_out are all 0. The flags bus packs {N, Z, C, V} in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | DATA_W | First operand (destination register value) |
| opnd_b | input | DATA_W | Second operand (register or immediate) |
| flags_in | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Registered result valid |
| wr_en | output | 1 | Write result to destination |
| result | output | DATA_W | Operation result |
| flags_out | output | 4 | Updated {N,Z,C,V} |

## Verification
The hardest cases to reach are the carry and overflow boundaries of the carry-consuming operations. Subtract-with-carry with a clear carry and equal operands must borrow. Add-with-carry must carry out only because of the incoming one. The bench reaches these by building the ALU at a 4-bit width and sweeping every operation code, every operand pair and all sixteen incoming flag patterns. Every such corner is then applied, and so are the negate of the most negative value and the pass-through of C and V across logic operations.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_SBC = 4'd3,
        OP_NEG = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_AND = 4'd8,
        OP_EOR = 4'd9,
        OP_ORR = 4'd10,
        OP_BIC = 4'd11,
        OP_MOV = 4'd12,
        OP_MVN = 4'd13
    } alu_op_e;

    localparam logic [3:0] OP_LAST_DEFINED = 4'd13;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_arith(input logic [3:0] op);
        return op <= 4'd6;
    endfunction

    function automatic logic op_is_flag_only(input logic [3:0] op);
        return (op == OP_CMP) || (op == OP_CMN) || (op == OP_TST);
    endfunction

endpackage

// File: rtl/cfa_addsub.sv
module cfa_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        sum  = full[MSB:0];
        cout = full[DATA_W];
        ovf  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    end
endmodule

// File: rtl/cfa_logic.sv
module cfa_logic
    import cfa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_TST, OP_AND: res = a & b;
            OP_EOR:         res = a ^ b;
            OP_ORR:         res = a | b;
            OP_BIC:         res = a & ~b;
            OP_MOV:         res = b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/cfa_alu.sv
module cfa_alu
    import cfa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [DATA_W-1:0] res;
        nzcv_t             fl;
    } stage_t;

    stage_t st_d, st_q;

    logic [DATA_W-1:0] add_x, add_y, add_sum, log_res;
    logic              add_cin, add_cout, add_ovf;
    nzcv_t             fin;

    assign fin = nzcv_t'(flags_in);

    // Operand steering: subtraction is x + ~y + carry-in
    always_comb begin
        add_x   = opnd_a;
        add_y   = opnd_b;
        add_cin = 1'b0;
        unique case (op_sel)
            OP_ADC:         add_cin = fin.c;
            OP_SUB, OP_CMP: begin add_y = ~opnd_b; add_cin = 1'b1; end
            OP_SBC:         begin add_y = ~opnd_b; add_cin = fin.c; end
            OP_NEG:         begin add_x = '0; add_y = ~opnd_b; add_cin = 1'b1; end
            default:        ;
        endcase
    end

    cfa_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    cfa_logic #(.DATA_W(DATA_W)) u_logic (
        .op(op_sel), .a(opnd_a), .b(opnd_b), .res(log_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wr  = 1'b0;
        if (in_valid) begin
            if (op_sel > OP_LAST_DEFINED) begin
                st_d.res = '0;
                st_d.fl  = fin;
            end else begin
                st_d.wr  = !op_is_flag_only(op_sel);
                st_d.res = op_is_arith(op_sel) ? add_sum : log_res;
                st_d.fl.n = st_d.res[MSB];
                st_d.fl.z = (st_d.res == '0);
                st_d.fl.c = op_is_arith(op_sel) ? add_cout : fin.c;
                st_d.fl.v = op_is_arith(op_sel) ? add_ovf  : fin.v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.wr;
    assign result    = st_q.res;
    assign flags_out = st_q.fl;

    // R6: flag-only operations never write
    p_flag_only_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_is_flag_only(op_sel) |=> !wr_en);

    // R7: logic ops keep C and V
    p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_sel >= 4'd7) && (op_sel <= OP_LAST_DEFINED)
        |=> flags_out[1:0] == $past(flags_in[1:0]));

    // R8: N and Z track the registered result
    p_nz_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_sel <= OP_LAST_DEFINED)
        |=> (flags_out[3] == result[MSB]) && (flags_out[2] == (result == '0)));

    // R9: idle cycle holds outputs and suppresses writes
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en && $stable(result) && $stable(flags_out));

    // R10: undefined codes pass flags, no write
    p_undef_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_sel > OP_LAST_DEFINED)
        |=> !wr_en && (result == '0) && (flags_out == $past(flags_in)));

    // R5: negate of zero is the only negate with carry set
    p_neg_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_sel == OP_NEG) |=> flags_out[1] == (result == '0));
endmodule

// File: tb/cfa_alu_test.sv
module cfa_alu_test;
    localparam int W    = 4;
    localparam int MOD  = 1 << W;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]   flags_in = '0;
    logic         out_valid, wr_en;
    logic [W-1:0] result;
    logic [3:0]   flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cfa_alu #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
        .out_valid(out_valid), .wr_en(wr_en), .result(result), .flags_out(flags_out)
    );

    function automatic int sx(input int v);
        return (v > SMAX) ? v - MOD : v;
    endfunction

    function automatic bit oor(input int s);
        return (s > SMAX) || (s < SMIN);
    endfunction

    function automatic string tag(input int op);
        case (op)
            0, 6:    return "R1 R8";
            1, 5:    return "R2 R8";
            2:       return "R3 R8";
            3:       return "R4 R8";
            4:       return "R5 R8";
            7:       return "R6 R8";
            8, 9, 10, 11, 12, 13: return "R7 R8";
            default: return "R10";
        endcase
    endfunction

    // Expected value packed as {wr, res[W-1:0], n, z, c, v}
    function automatic logic [W+4:0] model(input int op, input int a, input int b, input logic [3:0] fl);
        int r; bit c, v, wr; int ci;
        ci = fl[1];
        c = fl[1]; v = fl[0]; wr = 1;
        case (op)
            0, 6: begin r = a + b; c = (r >= MOD); v = oor(sx(a) + sx(b)); end
            1, 5: begin r = a - b; c = (a >= b); v = oor(sx(a) - sx(b)); end
            2:    begin r = a + b + ci; c = (r >= MOD); v = oor(sx(a) + sx(b) + ci); end
            3:    begin r = a - b - (1 - ci); c = (a >= b + (1 - ci)); v = oor(sx(a) - sx(b) - (1 - ci)); end
            4:    begin r = -b; c = (b == 0); v = oor(-sx(b)); end
            7, 8: r = a & b;
            9:    r = a ^ b;
            10:   r = a | b;
            11:   r = a & (~b);
            12:   r = b;
            13:   r = ~b;
            default: r = 0;
        endcase
        if (op == 5 || op == 6 || op == 7) wr = 0;
        r = ((r % MOD) + MOD) % MOD;
        if (op > 13) return {1'b0, W'(0), fl};
        return {wr, W'(r), (r >= MOD / 2), (r == 0), c, v};
    endfunction

    task automatic apply(input int op, input int a, input int b, input logic [3:0] fl);
        logic [W+4:0] exp_v, act_v;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 4'(op); opnd_a = W'(a); opnd_b = W'(b); flags_in = fl;
        @(posedge clk); #1;
        exp_v = model(op, a, b, fl);
        act_v = {wr_en, result, flags_out};
        checks++;
        if (act_v !== exp_v || out_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s op=%0d a=%0d b=%0d fl=%b: actual wr/res/nzcv=%b vld=%b expected=%b vld=1",
                     tag(op), op, a, b, fl, act_v, out_valid, exp_v);
        end
    endtask

    task automatic idle_check();
        logic [W+3:0] held;
        held = {result, flags_out};
        @(negedge clk);
        in_valid = 1'b0; flags_in = ~flags_in; opnd_a = ~opnd_a;
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || {result, flags_out} !== held) begin
            fails++;
            $display("FAIL R9 idle: actual vld=%b wr=%b res/fl=%b expected vld=0 wr=0 res/fl=%b",
                     out_valid, wr_en, {result, flags_out}, held);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 0 || wr_en !== 0 || result !== '0 || flags_out !== '0) begin
            fails++;
            $display("FAIL R11 reset: actual vld=%b wr=%b res=%b fl=%b expected all zero",
                     out_valid, wr_en, result, flags_out);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1..R10 exhaustive sweep at 4-bit width
        for (int fl = 0; fl < 16; fl++) begin
            for (int op = 0; op < 16; op++) begin
                for (int a = 0; a < MOD; a++)
                    for (int b = 0; b < MOD; b++)
                        apply(op, a, b, 4'(fl));
                idle_check();
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule